// File: doc/BRIEF.md
# ROM Entry List Walker

This block walks the chain of variable-length entries stored in a device configuration ROM. The ROM image is already held in a local byte memory. After a start pulse, the walker begins at byte 22, just past the fixed header, and steps from entry to entry using each entry's own length byte. It checks that every entry fits inside the image before using it. Entries that describe a port are decoded into per-port records. Each record holds a disabled flag, a link number and an optional dual-link partner, and is written through a simple write port into whatever port table the surrounding logic keeps.

Validating the header and loading the ROM into memory are left to neighbouring blocks. The caller supplies the total image size, which is the header's data length plus 13, and waits for the done pulse. An error code qualifies that pulse. It tells a clean end apart from an overrun, a malformed port entry, or a port index that the table cannot hold. Every error ends the walk at once. Records written before the error stay written.

Top module: `rom_entry_walker`

## Requirements
- R1: A start pulse while idle latches `total_size` and begins at position 22. The walk goes on while the position is below the size, so a size of 22 or less ends with done, no error and no record writes.
- R2: In an entry, byte 0 is the length. Byte 1 carries the index in bits 5:0, a disabled flag in bit 6 and the type in bit 7, where 1 means port. Entries with bit 7 clear are skipped without a write or an error, whatever their index bits hold.
- R3: The walk stops with error code 1 (overrun) in three cases: the position plus one equals the size, the position plus the length exceeds the size, or the length is zero.
- R4: After an accepted entry the position advances by its length. An entry that ends exactly at the size closes the walk without error. Two record writes are never in adjacent cycles.
- R5: A disabled port entry of any nonzero fitting length produces exactly one record, with disabled=1, link=0, partner flag=0 and partner number=0.
- R6: An enabled port entry whose length is not 8 stops the walk with error code 2 (bad length) and writes nothing.
- R7: An enabled 8-byte port entry writes one record with disabled=0. Its link is bit 4 of byte 2, its partner flag is bit 7 of byte 2, and its partner number is bits 5:0 of byte 3.
- R8: A port entry, disabled or not, whose index is not below the PORTS parameter stops the walk with error code 3 (bad index) and writes nothing. The index is checked before the length.
- R9: Each memory read is a one-cycle `rd_en` strobe whose byte is used on the next cycle. `rd_addr` is always below the latched size.
- R10: `done` is a single-cycle pulse. `error` (code not 0) and `err_code` are valid with it and hold until the next accepted start.
- R11: A start pulse during a walk is ignored, including the size presented with it.
- R12: In the done cycle, and until the next start, no reads and no record writes are issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (honoured only when idle) |
| total_size | input | ADDR_W | Image size in bytes (header plus data) |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | ADDR_W | Memory byte address |
| rd_data | input | 8 | Memory byte, valid the cycle after `rd_en` |
| rec_we | output | 1 | Port-record write strobe |
| rec_idx | output | PIDX_W | Port-record index |
| rec_disabled | output | 1 | Record: port disabled |
| rec_link | output | 1 | Record: link number |
| rec_has_partner | output | 1 | Record: dual-link partner present |
| rec_partner | output | 6 | Record: partner port number |
| done | output | 1 | One-cycle end-of-walk pulse |
| error | output | 1 | Walk ended with an error |
| err_code | output | 2 | 0 none, 1 overrun, 2 bad length, 3 bad index |

## Verification
The bench builds the walker with ADDR_W=11 and PORTS=8. With a table of only eight ports, an index such as 9 is still a legal 6-bit field but lies outside the table, so the bad-index path can be reached with short images. The 11-bit address covers every image size the 10-bit data length allows. The bench can therefore place lists that end exactly on the size, lists that leave one stray byte, and entries that cross the end, all within a 2 KiB model memory.

// File: rtl/rew_pkg.sv
package rew_pkg;

  // Offset of the first list entry (size of the fixed ROM header)
  localparam int unsigned LIST_START     = 22;
  // Required length of an enabled port entry
  localparam int unsigned PORT_ENTRY_LEN = 8;
  // Field positions inside port-entry byte 2
  localparam int unsigned LINK_BIT       = 4;
  localparam int unsigned PARTNER_BIT    = 7;
  localparam int unsigned PNUM_W         = 6;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_OVERRUN   = 2'd1,
    ERR_BAD_LEN   = 2'd2,
    ERR_BAD_INDEX = 2'd3
  } rew_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LEN,
    ST_HDR,
    ST_EVAL,
    ST_B2,
    ST_B3
  } rew_state_e;

  // Entry byte 1, most significant bit first
  typedef struct packed {
    logic       is_port;
    logic       disabled;
    logic [5:0] index;
  } rew_hdr_t;

endpackage

// File: rtl/rew_bounds.sv
// Position/size checks for the entry at the current position.
module rew_bounds #(
  parameter int unsigned POS_W = 12
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] size,
  input  logic [7:0]       len,
  output logic             at_end,
  output logic             one_left,
  output logic             len_bad
);

  localparam int unsigned SUM_W = POS_W + 1;

  logic [SUM_W-1:0] pos_ext;
  logic [SUM_W-1:0] size_ext;
  logic [SUM_W-1:0] pos_plus_one;
  logic [SUM_W-1:0] pos_plus_len;

  always_comb begin
    pos_ext      = {1'b0, pos};
    size_ext     = {1'b0, size};
    pos_plus_one = pos_ext + SUM_W'(1);
    pos_plus_len = pos_ext + SUM_W'(len);
    at_end       = (pos_ext >= size_ext);
    one_left     = (pos_plus_one == size_ext);
    len_bad      = (len == 8'd0) || (pos_plus_len > size_ext);
  end

endmodule

// File: rtl/rew_hdr_dec.sv
// Splits entry byte 1 and checks the index against the port table size.
module rew_hdr_dec #(
  parameter int unsigned PORTS = 16
) (
  input  logic [7:0] hdr_byte,
  output logic       is_port,
  output logic       disabled,
  output logic [5:0] index,
  output logic       idx_ok
);

  import rew_pkg::*;

  localparam logic [6:0] PORT_LIMIT = 7'(PORTS);

  rew_hdr_t hdr;

  always_comb begin
    hdr      = rew_hdr_t'(hdr_byte);
    is_port  = hdr.is_port;
    disabled = hdr.disabled;
    index    = hdr.index;
    idx_ok   = ({1'b0, hdr.index} < PORT_LIMIT);
  end

endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker #(
  parameter  int unsigned ADDR_W = 11,
  parameter  int unsigned PORTS  = 16,
  localparam int unsigned PIDX_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] total_size,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              rec_we,
  output logic [PIDX_W-1:0] rec_idx,
  output logic              rec_disabled,
  output logic              rec_link,
  output logic              rec_has_partner,
  output logic [5:0]        rec_partner,
  output logic              done,
  output logic              error,
  output logic [1:0]        err_code
);

  import rew_pkg::*;

  localparam int unsigned POS_W     = ADDR_W + 1;
  localparam logic [POS_W-1:0] FIRST_POS = POS_W'(LIST_START);
  localparam logic [7:0]       PORT_LEN  = 8'(PORT_ENTRY_LEN);

  // ---------------------------------------------------------------
  // State
  // ---------------------------------------------------------------
  rew_state_e       state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] size_q;
  logic             size_en;
  logic [7:0]       len_q;
  logic             len_en;
  logic [7:0]       hdr_q;
  logic             hdr_en;
  logic             b2_link_q, b2_part_q;
  logic             b2_en;

  logic              rec_we_q, rec_we_d;
  logic              rec_en;
  logic [PIDX_W-1:0] rec_idx_q, rec_idx_d;
  logic              rec_dis_q, rec_dis_d;
  logic              rec_link_q, rec_link_d;
  logic              rec_part_q, rec_part_d;
  logic [5:0]        rec_pnum_q, rec_pnum_d;

  logic     done_q, done_d;
  rew_err_e err_q, err_d;
  logic     err_en;

  logic [POS_W-1:0] rd_pos;
  logic [POS_W-1:0] next_pos;

  // ---------------------------------------------------------------
  // Helpers
  // ---------------------------------------------------------------
  logic       at_end, one_left, len_bad;
  logic       h_port, h_dis, h_idx_ok;
  logic [5:0] h_idx;

  rew_bounds #(.POS_W(POS_W)) u_bounds (
    .pos      (pos_q),
    .size     (size_q),
    .len      (len_q),
    .at_end   (at_end),
    .one_left (one_left),
    .len_bad  (len_bad)
  );

  rew_hdr_dec #(.PORTS(PORTS)) u_hdr_dec (
    .hdr_byte (hdr_q),
    .is_port  (h_port),
    .disabled (h_dis),
    .index    (h_idx),
    .idx_ok   (h_idx_ok)
  );

  assign next_pos = pos_q + POS_W'(len_q);

  // ---------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------
  always_comb begin
    state_d    = state_q;
    pos_d      = pos_q;
    size_en    = 1'b0;
    len_en     = 1'b0;
    hdr_en     = 1'b0;
    b2_en      = 1'b0;
    rd_en      = 1'b0;
    rd_pos     = pos_q;
    rec_we_d   = 1'b0;
    rec_en     = 1'b0;
    rec_idx_d  = rec_idx_q;
    rec_dis_d  = rec_dis_q;
    rec_link_d = rec_link_q;
    rec_part_d = rec_part_q;
    rec_pnum_d = rec_pnum_q;
    done_d     = 1'b0;
    err_en     = 1'b0;
    err_d      = err_q;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          size_en = 1'b1;
          pos_d   = FIRST_POS;
          err_en  = 1'b1;
          err_d   = ERR_NONE;
          state_d = ST_CHECK;
        end
      end

      ST_CHECK: begin
        if (at_end) begin
          done_d  = 1'b1;
          err_en  = 1'b1;
          err_d   = ERR_NONE;
          state_d = ST_IDLE;
        end else if (one_left) begin
          done_d  = 1'b1;
          err_en  = 1'b1;
          err_d   = ERR_OVERRUN;
          state_d = ST_IDLE;
        end else begin
          rd_en   = 1'b1;
          rd_pos  = pos_q;
          state_d = ST_LEN;
        end
      end

      ST_LEN: begin
        len_en  = 1'b1;
        rd_en   = 1'b1;
        rd_pos  = pos_q + POS_W'(1);
        state_d = ST_HDR;
      end

      ST_HDR: begin
        hdr_en  = 1'b1;
        state_d = ST_EVAL;
      end

      ST_EVAL: begin
        if (len_bad) begin
          done_d  = 1'b1;
          err_en  = 1'b1;
          err_d   = ERR_OVERRUN;
          state_d = ST_IDLE;
        end else if (!h_port) begin
          pos_d   = next_pos;
          state_d = ST_CHECK;
        end else if (!h_idx_ok) begin
          done_d  = 1'b1;
          err_en  = 1'b1;
          err_d   = ERR_BAD_INDEX;
          state_d = ST_IDLE;
        end else if (h_dis) begin
          rec_we_d   = 1'b1;
          rec_en     = 1'b1;
          rec_idx_d  = h_idx[PIDX_W-1:0];
          rec_dis_d  = 1'b1;
          rec_link_d = 1'b0;
          rec_part_d = 1'b0;
          rec_pnum_d = '0;
          pos_d      = next_pos;
          state_d    = ST_CHECK;
        end else if (len_q != PORT_LEN) begin
          done_d  = 1'b1;
          err_en  = 1'b1;
          err_d   = ERR_BAD_LEN;
          state_d = ST_IDLE;
        end else begin
          rd_en   = 1'b1;
          rd_pos  = pos_q + POS_W'(2);
          state_d = ST_B2;
        end
      end

      ST_B2: begin
        b2_en   = 1'b1;
        rd_en   = 1'b1;
        rd_pos  = pos_q + POS_W'(3);
        state_d = ST_B3;
      end

      ST_B3: begin
        rec_we_d   = 1'b1;
        rec_en     = 1'b1;
        rec_idx_d  = h_idx[PIDX_W-1:0];
        rec_dis_d  = 1'b0;
        rec_link_d = b2_link_q;
        rec_part_d = b2_part_q;
        rec_pnum_d = rd_data[PNUM_W-1:0];
        pos_d      = next_pos;
        state_d    = ST_CHECK;
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pos_q    <= '0;
      rec_we_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      state_q  <= state_d;
      pos_q    <= pos_d;
      rec_we_q <= rec_we_d;
      done_q   <= done_d;
      if (err_en) err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q    <= '0;
      len_q     <= '0;
      hdr_q     <= '0;
      b2_link_q <= 1'b0;
      b2_part_q <= 1'b0;
    end else begin
      if (size_en) size_q <= {1'b0, total_size};
      if (len_en)  len_q  <= rd_data;
      if (hdr_en)  hdr_q  <= rd_data;
      if (b2_en) begin
        b2_link_q <= rd_data[LINK_BIT];
        b2_part_q <= rd_data[PARTNER_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_idx_q  <= '0;
      rec_dis_q  <= 1'b0;
      rec_link_q <= 1'b0;
      rec_part_q <= 1'b0;
      rec_pnum_q <= '0;
    end else if (rec_en) begin
      rec_idx_q  <= rec_idx_d;
      rec_dis_q  <= rec_dis_d;
      rec_link_q <= rec_link_d;
      rec_part_q <= rec_part_d;
      rec_pnum_q <= rec_pnum_d;
    end
  end

  // ---------------------------------------------------------------
  // Outputs
  // ---------------------------------------------------------------
  assign rd_addr         = rd_pos[ADDR_W-1:0];
  assign rec_we          = rec_we_q;
  assign rec_idx         = rec_idx_q;
  assign rec_disabled    = rec_dis_q;
  assign rec_link        = rec_link_q;
  assign rec_has_partner = rec_part_q;
  assign rec_partner     = rec_pnum_q;
  assign done            = done_q;
  assign err_code        = err_q;
  assign error           = (err_q != ERR_NONE);

endmodule

// File: rtl/rew_checker.sv
module rew_checker #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned POS_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [POS_W-1:0]  size_q,
  input logic              rec_we,
  input logic              rec_disabled,
  input logic              rec_link,
  input logic              rec_has_partner,
  input logic [5:0]        rec_partner,
  input logic              done,
  input logic              error
);

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: an error only appears together with done
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  // R10: error holds between done and the next start
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(error) || done));

  // R9: reads stay inside the image
  p_rd_in_image_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ({1'b0, rd_addr} < size_q));

  // R5: disabled records carry no link or partner data
  p_dis_rec_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_we && rec_disabled) |-> (!rec_link && !rec_has_partner && (rec_partner == 6'd0)));

  // R12: the finishing cycle is quiet
  p_quiet_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_en && !rec_we));

  // R4: record writes are separated by at least one cycle
  p_write_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |=> !rec_we);

endmodule

bind rom_entry_walker rew_checker #(
  .ADDR_W (ADDR_W),
  .POS_W  (POS_W)
) u_rew_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .start           (start),
  .rd_en           (rd_en),
  .rd_addr         (rd_addr),
  .size_q          (size_q),
  .rec_we          (rec_we),
  .rec_disabled    (rec_disabled),
  .rec_link        (rec_link),
  .rec_has_partner (rec_has_partner),
  .rec_partner     (rec_partner),
  .done            (done),
  .error           (error)
);

// File: tb/test_rom_entry_walker.sv
module test_rom_entry_walker;

  localparam int unsigned ADDR_W = 11;
  localparam int unsigned PORTS  = 8;
  localparam int unsigned PIDX_W = 3;
  localparam int unsigned MEM_SZ = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [ADDR_W-1:0] total_size;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              rec_we;
  logic [PIDX_W-1:0] rec_idx;
  logic              rec_disabled, rec_link, rec_has_partner;
  logic [5:0]        rec_partner;
  logic              done, error;
  logic [1:0]        err_code;

  rom_entry_walker #(.ADDR_W(ADDR_W), .PORTS(PORTS)) i_rom_entry_walker (
    .clk, .rst_n, .start, .total_size, .rd_en, .rd_addr, .rd_data,
    .rec_we, .rec_idx, .rec_disabled, .rec_link, .rec_has_partner,
    .rec_partner, .done, .error, .err_code
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Byte memory with one-cycle read latency
  logic [7:0] mem [0:MEM_SZ-1];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  // Record capture
  logic       clr_req;
  int         wr_cnt, done_cnt, bad_rd, cur_size;
  logic       seen  [0:PORTS-1];
  logic       r_dis [0:PORTS-1];
  logic       r_lnk [0:PORTS-1];
  logic       r_hp  [0:PORTS-1];
  logic [5:0] r_pn  [0:PORTS-1];

  always @(posedge clk) begin
    if (clr_req) begin
      wr_cnt = 0; done_cnt = 0; bad_rd = 0;
      for (int i = 0; i < PORTS; i++) begin
        seen[i] = 0; r_dis[i] = 0; r_lnk[i] = 0; r_hp[i] = 0; r_pn[i] = 0;
      end
    end else begin
      if (rec_we) begin
        wr_cnt++;
        seen[rec_idx]  = 1'b1;
        r_dis[rec_idx] = rec_disabled;
        r_lnk[rec_idx] = rec_link;
        r_hp[rec_idx]  = rec_has_partner;
        r_pn[rec_idx]  = rec_partner;
      end
      if (done) done_cnt++;
      if (rd_en && (int'(rd_addr) >= cur_size)) bad_rd++;
    end
  end

  int  tests, fails;
  bit  finished;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int a = 0; a < MEM_SZ; a++) mem[a] = 8'hEE;
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  task automatic put(input int pos, input int len, input int hdr, input int b2, input int b3);
    mem[pos]   = 8'(len);
    mem[pos+1] = 8'(hdr);
    mem[pos+2] = 8'(b2);
    mem[pos+3] = 8'(b3);
  endtask

  // Start a walk, optionally pulse a second start mid-walk, then wait for done
  task automatic walk(input int size, input bit poke);
    int n;
    cur_size = size;
    @(negedge clk); total_size = ADDR_W'(size); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      total_size = ADDR_W'(22); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R10 done seen", done, 1);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    chk(!rd_en && !rec_we, "R12 quiet after done", rd_en, 0);
  endtask

  task automatic expect_rec(input int idx, input int d, input int l, input int hp, input int pn, input string req);
    chk(seen[idx] == 1, {req, " record written"}, seen[idx], 1);
    chk(r_dis[idx] == d && r_lnk[idx] == l && r_hp[idx] == hp && r_pn[idx] == pn,
        {req, " record fields"}, {r_dis[idx], r_lnk[idx], r_hp[idx], r_pn[idx]},
        {1'(d), 1'(l), 1'(hp), 6'(pn)});
  endtask

  task automatic t_reset();
    chk(!done && !error && err_code == 0 && !rd_en && !rec_we, "R10 reset state",
        {done, error, rd_en, rec_we}, 0);
  endtask

  task automatic t_short();
    clear_all();
    walk(22, 0);
    chk(!error && wr_cnt == 0, "R1 size 22 empty list", wr_cnt, 0);
    clear_all();
    walk(10, 0);
    chk(!error && wr_cnt == 0 && err_code == 0, "R1 size below header", err_code, 0);
  endtask

  task automatic build_mixed();
    put(22, 5, 8'h3F, 0, 0);        // generic entry, index bits 63 (R2)
    put(27, 8, 8'h81, 8'h90, 8'h02); // enabled port 1, link 1, partner 2
    put(35, 2, 8'hC3, 0, 0);        // disabled port 3, short
    put(37, 8, 8'h82, 8'h6F, 8'hFF); // enabled port 2, link 0, no partner, pn 63
  endtask

  task automatic t_mixed();
    clear_all();
    build_mixed();
    walk(45, 0);
    chk(err_code == 0, "R4 exact end no error", err_code, 0);
    chk(wr_cnt == 3, "R2 generic skipped, 3 writes", wr_cnt, 3);
    expect_rec(1, 0, 1, 1, 2, "R7 port1");
    expect_rec(2, 0, 0, 0, 63, "R7 port2 masked fields");
    expect_rec(3, 1, 0, 0, 0, "R5 disabled port3");
    chk(bad_rd == 0, "R9 reads inside image", bad_rd, 0);
  endtask

  task automatic t_busy_start();
    clear_all();
    build_mixed();
    walk(45, 1);
    chk(wr_cnt == 3 && err_code == 0, "R11 restart ignored", wr_cnt, 3);
    chk(done_cnt == 1, "R11 single done", done_cnt, 1);
  endtask

  task automatic t_overrun();
    clear_all();
    put(22, 5, 8'h00, 0, 0);
    walk(28, 0);
    chk(err_code == 1 && error, "R3 one byte left", err_code, 1);
    clear_all();
    put(22, 9, 8'h81, 8'h10, 0);
    walk(30, 0);
    chk(err_code == 1 && wr_cnt == 0, "R3 length past end", err_code, 1);
    clear_all();
    put(22, 0, 8'h81, 0, 0);
    walk(40, 0);
    chk(err_code == 1 && wr_cnt == 0, "R3 zero length", err_code, 1);
    chk(bad_rd == 0, "R9 no read past end", bad_rd, 0);
  endtask

  task automatic t_bad_len();
    clear_all();
    put(22, 7, 8'h81, 8'h90, 8'h01);
    walk(29, 0);
    chk(err_code == 2 && wr_cnt == 0, "R6 enabled port length 7", err_code, 2);
  endtask

  task automatic t_bad_index();
    clear_all();
    put(22, 8, 8'h80, 8'h10, 8'h05);   // port 0, link 1, no partner
    put(30, 3, 8'hC9, 0, 0);           // disabled port 9 >= PORTS
    walk(45, 0);
    chk(err_code == 3 && wr_cnt == 1, "R8 index 9 rejected", err_code, 3);
    expect_rec(0, 0, 1, 0, 5, "R8 earlier record kept");
    clear_all();
    put(22, 5, 8'h8A, 0, 0);           // index 10, wrong length: index first
    walk(27, 0);
    chk(err_code == 3, "R8 index checked before length", err_code, 3);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; total_size = '0; clr_req = 1'b0;
    tests = 0; fails = 0; finished = 0; cur_size = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_mixed();
    t_busy_start();
    t_overrun();
    t_bad_len();
    t_bad_index();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule